// File: doc/BRIEF.md
# Two-Class Round-Robin Request Arbiter

This block picks one winner per cycle among a small set of requesters, using a two-level policy. Each requester presents a valid bit and a 4-bit QoS value. Only the value 15 places a request in the high class; every other value places it in the low class. A high-class request always wins over a low-class one. Within a class, a rotating pointer shares the grants fairly. The two classes keep separate pointers, so traffic in one class does not change the order in the other.

Two instances of the same core are placed side by side. The first chooses among three request ports that feed a transaction tracker. The second chooses which of four tracker entries is issued next. Each instance has a downstream ready input. A grant is shown combinationally in the same cycle, and it is taken as accepted when ready is high. Fairness across classes is not attempted: low-class requests can wait for as long as high-class requests keep arriving.

Top module: `qos_port_arbiter`

## Requirements
- R1: Each grant vector (`port_grant`, `issue_grant`) has at most one bit set. When a bit is set, the matching `*_grant_idx` equals that bit's position.
- R2: A request is high class exactly when its QoS field equals 4'hF. For port i, the field is `port_qos[4*i+3:4*i]`, and the same layout applies to `entry_qos`. The values 0 to 14 are low class. `*_grant_hi` is 1 when the grant is a high-class one.
- R3: When ready is high and any valid request is high class, the grant goes to a high-class request.
- R4: Within a class, the winner is the first requesting index at or after that class's pointer, searched upward and wrapping. After an accepted grant to index w, the class pointer becomes (w+1) mod N.
- R5: An accepted grant in one class leaves the other class's pointer unchanged.
- R6: While ready is low, no grant is asserted and both pointers hold their values.
- R7: With no valid request, no grant is asserted. `*_grant_idx` and `*_grant_hi` then read 0.
- R8: After reset, both pointers of both instances are 0, so the first grant in a class goes to the lowest requesting index.
- R9: The issue selector over four tracker entries applies the same class-then-rotation policy. Its pointers are independent of the port selector's pointers.
- R10: A grant appears combinationally in the cycle the request and ready are present. A pointer update takes effect from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_valid | input | 3 | Request valid per port |
| port_qos | input | 12 | 4-bit QoS per port, port i at bits 4i+3:4i |
| alloc_ready | input | 1 | Tracker can accept an allocation this cycle |
| port_grant | output | 3 | One-hot grant; also the per-port ready |
| port_grant_idx | output | 2 | Index of the granted port |
| port_grant_hi | output | 1 | Granted port request is high class |
| entry_valid | input | 4 | Tracker entry is issuable |
| entry_qos | input | 16 | 4-bit QoS per entry, entry i at bits 4i+3:4i |
| issue_ready | input | 1 | Downstream can accept an issue this cycle |
| issue_grant | output | 4 | One-hot issue selection |
| issue_grant_idx | output | 2 | Index of the selected entry |
| issue_grant_hi | output | 1 | Selected entry is high class |

## Verification
Grants are combinational, so the result of a stimulus is due in the same cycle it is driven. The pointer updates caused by that grant first show in the grants of the next cycle. The driver applies inputs at the falling edge and pushes the expected grants from its own model onto a queue. The monitor pops and compares them two nanoseconds later, before the rising edge that commits the pointers. The model advances its own pointers only when it predicts an accepted grant, so every following entry in the queue checks that the pointers moved or held as required.

// File: rtl/qarb_pkg.sv
package qarb_pkg;
  localparam int QOS_W = 4;
  localparam logic [QOS_W-1:0] QOS_TOP = '1;

  typedef enum logic { CLS_LO = 1'b0, CLS_HI = 1'b1 } cls_e;

  function automatic cls_e qos_class(input logic [QOS_W-1:0] q);
    return (q == QOS_TOP) ? CLS_HI : CLS_LO;
  endfunction
endpackage

// File: rtl/qarb_class_split.sv
module qarb_class_split
  import qarb_pkg::*;
#(
  parameter int N = 3
) (
  input  logic [N-1:0]       req_valid,
  input  logic [N*QOS_W-1:0] req_qos,
  output logic [N-1:0]       hi_req,
  output logic [N-1:0]       lo_req
);
  for (genvar i = 0; i < N; i++) begin : g_lane
    logic is_hi;
    assign is_hi     = (qos_class(req_qos[i*QOS_W +: QOS_W]) == CLS_HI);
    assign hi_req[i] = req_valid[i] & is_hi;
    assign lo_req[i] = req_valid[i] & ~is_hi;
  end
endmodule

// File: rtl/qarb_rr_pick.sv
module qarb_rr_pick #(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic [N-1:0]  pick_oh,
  output logic [IW-1:0] pick_idx,
  output logic          pick_any
);
  always_comb begin
    pick_oh  = '0;
    pick_idx = '0;
    pick_any = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!pick_any && req[j]) begin
        pick_any   = 1'b1;
        pick_oh[j] = 1'b1;
        pick_idx   = j[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/qarb_class_arb.sv
module qarb_class_arb
  import qarb_pkg::*;
#(
  parameter int N  = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       req_valid,
  input  logic [N*QOS_W-1:0] req_qos,
  input  logic               dn_ready,
  output logic [N-1:0]       gnt,
  output logic [IW-1:0]      gnt_idx,
  output logic               gnt_hi
);
  logic [N-1:0]  hi_req, lo_req;
  logic [N-1:0]  hi_oh, lo_oh;
  logic [IW-1:0] hi_idx, lo_idx;
  logic          hi_any, lo_any;
  logic [IW-1:0] hi_ptr, lo_ptr;
  logic          take_hi, take_lo;

  function automatic logic [IW-1:0] wrap_next(input logic [IW-1:0] w);
    return (int'(w) == N - 1) ? '0 : w + 1'b1;
  endfunction

  qarb_class_split #(.N(N)) u_split (
    .req_valid (req_valid),
    .req_qos   (req_qos),
    .hi_req    (hi_req),
    .lo_req    (lo_req)
  );

  qarb_rr_pick #(.N(N)) u_pick_hi (
    .req (hi_req), .ptr (hi_ptr),
    .pick_oh (hi_oh), .pick_idx (hi_idx), .pick_any (hi_any)
  );

  qarb_rr_pick #(.N(N)) u_pick_lo (
    .req (lo_req), .ptr (lo_ptr),
    .pick_oh (lo_oh), .pick_idx (lo_idx), .pick_any (lo_any)
  );

  // accepted-grant events, named for the checks below
  assign take_hi = dn_ready & hi_any;
  assign take_lo = dn_ready & ~hi_any & lo_any;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_hi  = 1'b0;
    if (take_hi) begin
      gnt     = hi_oh;
      gnt_idx = hi_idx;
      gnt_hi  = 1'b1;
    end else if (take_lo) begin
      gnt     = lo_oh;
      gnt_idx = lo_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_ptr <= '0;
      lo_ptr <= '0;
    end else begin
      if (take_hi) hi_ptr <= wrap_next(hi_idx);
      if (take_lo) lo_ptr <= wrap_next(lo_idx);
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R1
  AST_GNT_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0) |-> gnt[gnt_idx]); // R1
  AST_GNT_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req_valid) == '0); // R7
  AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_ready && (hi_req != '0)) |-> ((gnt & hi_req) != '0)); // R3
  AST_NO_GNT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !dn_ready |-> (gnt == '0)); // R6
  AST_PTR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt == '0) |=> ($stable(hi_ptr) && $stable(lo_ptr))); // R6
  AST_LO_PTR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_hi |=> $stable(lo_ptr)); // R5
  AST_HI_PTR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt != '0) && !gnt_hi) |=> $stable(hi_ptr)); // R5
endmodule

// File: rtl/qos_port_arbiter.sv
module qos_port_arbiter
  import qarb_pkg::*;
#(
  parameter int N_PORTS   = 3,
  parameter int N_ENTRIES = 4,
  localparam int PW = (N_PORTS > 1)   ? $clog2(N_PORTS)   : 1,
  localparam int EW = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PORTS-1:0]         port_valid,
  input  logic [N_PORTS*QOS_W-1:0]   port_qos,
  input  logic                       alloc_ready,
  output logic [N_PORTS-1:0]         port_grant,
  output logic [PW-1:0]              port_grant_idx,
  output logic                       port_grant_hi,
  input  logic [N_ENTRIES-1:0]       entry_valid,
  input  logic [N_ENTRIES*QOS_W-1:0] entry_qos,
  input  logic                       issue_ready,
  output logic [N_ENTRIES-1:0]       issue_grant,
  output logic [EW-1:0]              issue_grant_idx,
  output logic                       issue_grant_hi
);
  // allocation: choose among request ports (R1..R8)
  qarb_class_arb #(.N(N_PORTS)) u_port_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (port_valid),
    .req_qos   (port_qos),
    .dn_ready  (alloc_ready),
    .gnt       (port_grant),
    .gnt_idx   (port_grant_idx),
    .gnt_hi    (port_grant_hi)
  );

  // issue: same policy over tracker entries, own pointers (R9)
  qarb_class_arb #(.N(N_ENTRIES)) u_issue_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (entry_valid),
    .req_qos   (entry_qos),
    .dn_ready  (issue_ready),
    .gnt       (issue_grant),
    .gnt_idx   (issue_grant_idx),
    .gnt_hi    (issue_grant_hi)
  );
endmodule

// File: tb/qos_port_arbiter_tb.sv
module qos_port_arbiter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  port_valid = '0;
  logic [11:0] port_qos = '0;
  logic        alloc_ready = 1'b0;
  logic [2:0]  port_grant;
  logic [1:0]  port_grant_idx;
  logic        port_grant_hi;
  logic [3:0]  entry_valid = '0;
  logic [15:0] entry_qos = '0;
  logic        issue_ready = 1'b0;
  logic [3:0]  issue_grant;
  logic [1:0]  issue_grant_idx;
  logic        issue_grant_hi;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  qos_port_arbiter u_dut (
    .clk (clk), .rst_n (rst_n),
    .port_valid (port_valid), .port_qos (port_qos), .alloc_ready (alloc_ready),
    .port_grant (port_grant), .port_grant_idx (port_grant_idx),
    .port_grant_hi (port_grant_hi),
    .entry_valid (entry_valid), .entry_qos (entry_qos), .issue_ready (issue_ready),
    .issue_grant (issue_grant), .issue_grant_idx (issue_grant_idx),
    .issue_grant_hi (issue_grant_hi)
  );

  typedef struct {
    logic [2:0] pg; int pidx; bit phi;
    logic [3:0] ig; int iidx; bit ihi;
    string tag;
  } exp_t;
  exp_t sb[$];
  event pushed;

  // bench model state: pointers per class per selector
  int m_phi = 0, m_plo = 0, m_ehi = 0, m_elo = 0;

  function automatic int first_from(input int n, input logic [3:0] req, input int ptr);
    for (int k = 0; k < n; k++) begin
      if (req[(ptr + k) % n]) return (ptr + k) % n;
    end
    return -1;
  endfunction

  task automatic model(input int n, input logic [3:0] v, input logic [15:0] q,
                       input logic rdy, inout int ph, inout int pl,
                       output int idx, output bit hi, output bit g);
    logic [3:0] hr, lr;
    hr = '0; lr = '0;
    for (int i = 0; i < n; i++) begin
      hr[i] = v[i] && (q[i*4 +: 4] == 4'd15);
      lr[i] = v[i] && !hr[i];
    end
    idx = 0; hi = 0; g = 0;
    if (rdy && hr != '0) begin
      idx = first_from(n, hr, ph); hi = 1; g = 1; ph = (idx + 1) % n;
    end else if (rdy && lr != '0) begin
      idx = first_from(n, lr, pl); g = 1; pl = (idx + 1) % n;
    end
  endtask

  task automatic drive(input logic [2:0] pv, input logic [11:0] pq, input logic ar,
                       input logic [3:0] ev, input logic [15:0] eq, input logic ir,
                       input string tag);
    exp_t e; int idx; bit hi, g;
    @(negedge clk);
    port_valid = pv; port_qos = pq; alloc_ready = ar;
    entry_valid = ev; entry_qos = eq; issue_ready = ir;
    model(3, {1'b0, pv}, {4'h0, pq}, ar, m_phi, m_plo, idx, hi, g);
    e.pg = g ? 3'(1 << idx) : 3'b0; e.pidx = idx; e.phi = hi;
    model(4, ev, eq, ir, m_ehi, m_elo, idx, hi, g);
    e.ig = g ? 4'(1 << idx) : 4'b0; e.iidx = idx; e.ihi = hi;
    e.tag = tag;
    sb.push_back(e);
    -> pushed;
  endtask

  // monitor: compare 2 ns after drive, before the committing edge
  initial begin
    forever begin
      @(pushed);
      #2;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (port_grant !== e.pg || int'(port_grant_idx) != e.pidx || port_grant_hi !== e.phi) begin
          errors++;
          $display("FAIL %s port: grant=%b idx=%0d hi=%0b expected grant=%b idx=%0d hi=%0b",
                   e.tag, port_grant, port_grant_idx, port_grant_hi, e.pg, e.pidx, e.phi);
        end
        checks++;
        if (issue_grant !== e.ig || int'(issue_grant_idx) != e.iidx || issue_grant_hi !== e.ihi) begin
          errors++;
          $display("FAIL %s issue: grant=%b idx=%0d hi=%0b expected grant=%b idx=%0d hi=%0b",
                   e.tag, issue_grant, issue_grant_idx, issue_grant_hi, e.ig, e.iidx, e.ihi);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [11:0] PLO = 12'h123;        // all ports low class
  localparam logic [15:0] ELO = 16'h0000;       // all entries low class

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R8: pointers start at 0
    drive(3'b111, PLO, 1, 4'b1111, ELO, 1, "R8 reset");
    // R4: rotation among low-class ports and entries
    drive(3'b111, PLO, 1, 4'b1111, ELO, 1, "R4 rot1");
    drive(3'b111, PLO, 1, 4'b1111, ELO, 1, "R4 rot2");
    drive(3'b111, PLO, 1, 4'b1111, ELO, 1, "R4 wrap");
    drive(3'b101, PLO, 1, 4'b1010, ELO, 1, "R4 skip");
    // R2: QoS 15 on port 2 is high; QoS 14 on port 1 stays low
    drive(3'b111, 12'hFE0, 1, 4'b1111, 16'hF000, 1, "R2 class");
    // R3: high wins over low repeatedly, rotation among high
    drive(3'b111, 12'hF0F, 1, 4'b1111, 16'h0FF0, 1, "R3 hi1");
    drive(3'b111, 12'hF0F, 1, 4'b1111, 16'h0FF0, 1, "R3 hi2");
    drive(3'b111, 12'hF0F, 1, 4'b1111, 16'h0FF0, 1, "R3 hi3");
    // R5: low pointer untouched by the high grants
    drive(3'b111, PLO, 1, 4'b1111, ELO, 1, "R5 lo resume");
    // R6: ready low blocks grants, pointers held
    drive(3'b111, 12'hF00, 0, 4'b1111, 16'hF000, 0, "R6 stall");
    drive(3'b111, 12'hF00, 0, 4'b0110, ELO, 0, "R6 stall2");
    drive(3'b111, 12'hF00, 1, 4'b1111, 16'hF000, 1, "R6 release");
    // R7: nothing valid
    drive(3'b000, 12'hFFF, 1, 4'b0000, 16'hFFFF, 1, "R7 idle");
    // R9: ports and entries with opposite readiness
    drive(3'b011, PLO, 0, 4'b1001, 16'hF00F, 1, "R9 issue only");
    drive(3'b011, PLO, 1, 4'b1001, 16'hF00F, 0, "R9 alloc only");
    drive(3'b110, PLO, 1, 4'b1001, 16'hF00F, 1, "R9 both");
    // R10 / R1: mixed patterns, single-requester and alternating classes
    for (int c = 0; c < 24; c++) begin
      logic [2:0] pv; logic [11:0] pq; logic [3:0] ev; logic [15:0] eq;
      pv = 3'((c * 5 + 3) % 8);
      pq = (c % 3 == 0) ? 12'hF00 : ((c % 3 == 1) ? 12'h0F7 : 12'hE21);
      ev = 4'((c * 7 + 1) % 16);
      eq = (c % 4 == 0) ? 16'hF0F0 : ((c % 4 == 1) ? 16'h0E0F : 16'h1234);
      drive(pv, pq, (c % 5) != 4, ev, eq, (c % 6) != 5, "R10 R1 mix");
    end
    @(negedge clk);
    #4;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule